// File: doc/BRIEF.md
# Paired Lookup Record Store

This block is the hidden storage that sits inside a table-lookup execution unit and joins the two phases of a split lookup. The first phase computes a 46-bit intermediate record and puts it into the store. A later second-phase operation gets that record back, uses it to finish the result and frees the entry. Because the record stays inside the unit, the pair of operations needs no register-file result between them.

A parameter picks how puts and gets are paired. In FIFO mode, gets take records in the order they were put, and any tag inputs are ignored. In tagged mode, every put, get and restore carries a small immediate tag that names one slot. Matching pairs can then run in any order relative to other pairs. The number of slots is the smallest power of two that is at least the floating-point operation latency.

For context switches, the store drives a busy flag while any entry is live. It also has a flush, a save sequence and a restore port. The save sequence drains the live entries one per cycle. The restore port writes saved entries back.

Top module: `slotStore`

## Requirements
- R1: After reset every slot is empty. busy, getOk, errPut, errGet and saveValid are 0, and getData, saveTag and saveData are zero.
- R2: In FIFO mode a get returns the oldest record still held. getOk and getData are valid in the same cycle as getValid. The entry is freed at that clock edge.
- R3: In FIFO mode with all slots full, a put raises errPut for that cycle and the record is dropped. If a get is made in the same cycle, the put is accepted and errPut stays 0.
- R4: In FIFO mode a get while empty raises errGet, keeps getOk at 0 and returns getData zero. A put made in the same cycle is not visible to that get.
- R5: In tagged mode a get with tag t returns the record last written to slot t and frees only that slot. The order of gets across different tags is free.
- R6: In tagged mode a put to a slot that is still valid replaces its record and raises errPut. If a get of the same slot is made in the same cycle, the get returns the old record, the slot keeps the new one and errPut stays 0.
- R7: In tagged mode a get of an empty slot raises errGet, keeps getOk at 0 and returns getData zero.
- R8: The slot count is 2^ceil(log2(FP_LATENCY)). With the default FP_LATENCY of 6 this is 8 slots, addressed by 3-bit tags. Every record bit, including bit 45, is held.
- R9: busy is 1 exactly when at least one slot holds a record.
- R10: flush empties every slot at the clock edge and stops a save sequence. In that cycle put, get, restore and saveReq have no effect and raise no error.
- R11: saveReq, when records remain after that cycle, starts a drain from the next cycle. The drain presents one record per cycle on saveValid/saveTag/saveData and frees it. FIFO mode drains oldest first. Tagged mode drains the lowest valid slot first. saveTag is the slot index, and FIFO slots are filled at 0,1,2,... wrapping at the slot count, counting from reset or flush. While draining, put, get, restore and saveReq are ignored: getOk, errPut and errGet stay 0.
- R12: A restore (rstrValid) writes rstrData without raising an error. In FIFO mode it appends as the newest record and is dropped when full with no get that cycle. In tagged mode it writes slot rstrTag. A put in the same cycle takes precedence and the restore is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| putValid | input | 1 | First-phase put request |
| putTag | input | IDX_W | Slot tag of the put (tagged mode) |
| putData | input | REC_W | Record to store |
| getValid | input | 1 | Second-phase get request |
| getTag | input | IDX_W | Slot tag of the get (tagged mode) |
| getData | output | REC_W | Retrieved record, zero unless getOk |
| getOk | output | 1 | Get found a record |
| errPut | output | 1 | Overflow (FIFO) or overwrite (tagged) |
| errGet | output | 1 | Get of an empty store or slot |
| flush | input | 1 | Discard all records |
| saveReq | input | 1 | Start a save drain |
| saveValid | output | 1 | A drained record is presented |
| saveTag | output | IDX_W | Slot index of the drained record |
| saveData | output | REC_W | Drained record |
| rstrValid | input | 1 | Restore write request |
| rstrTag | input | IDX_W | Restore slot (tagged mode) |
| rstrData | input | REC_W | Record to restore |
| busy | output | 1 | Some slot holds a record |

## Verification
The bench drives one FIFO instance and one tagged instance with the same stimulus. It targets the cycles where two requests hit the same slot. A get and a put on a full FIFO must both succeed. A design that tested fullness before the free would report a false overflow. A same-cycle get and put on one tag must return the old record and keep the new one. A design that read after the write would return the new record, and one that cleared after the set would lose it. A get on an empty store made together with a put must still fail, which catches a bypass path. Flush and the save drain are issued with competing put, get and restore requests. A wrong priority would show up as stray errors, records left behind, or a drain in the wrong slot order.

// File: rtl/slotStorePkg.sv
package slotStorePkg;

  typedef enum logic {
    PAIR_FIFO   = 1'b0,
    PAIR_TAGGED = 1'b1
  } pairModeT;

  // Strobes from control to the record array
  typedef struct packed {
    logic wrEn;
    logic wrFromRestore;
    logic getEn;
    logic saveEn;
  } slotStrobeT;

endpackage

// File: rtl/slotStoreData.sv
module slotStoreData
  import slotStorePkg::*;
#(
  parameter int REC_W = 46,
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotStrobeT       stb,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] getIdx,
  input  logic [IDX_W-1:0] saveIdx,
  input  logic [REC_W-1:0] putData,
  input  logic [REC_W-1:0] rstrData,
  output logic [REC_W-1:0] getData,
  output logic [REC_W-1:0] saveData
);

  logic [REC_W-1:0] recMem [DEPTH];
  logic [REC_W-1:0] wrData;

  assign wrData = stb.wrFromRestore ? rstrData : putData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) recMem[i] <= '0;
    end else if (stb.wrEn) begin
      recMem[wrIdx] <= wrData;
    end
  end

  // Reads see the contents before this cycle's write
  assign getData  = stb.getEn  ? recMem[getIdx]  : '0;
  assign saveData = stb.saveEn ? recMem[saveIdx] : '0;

endmodule

// File: rtl/slotStoreCtrl.sv
module slotStoreCtrl
  import slotStorePkg::*;
#(
  parameter pairModeT MODE  = PAIR_FIFO,
  parameter int       DEPTH = 8,
  parameter int       IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             putValid,
  input  logic [IDX_W-1:0] putTag,
  input  logic             getValid,
  input  logic [IDX_W-1:0] getTag,
  input  logic             flush,
  input  logic             saveReq,
  input  logic             rstrValid,
  input  logic [IDX_W-1:0] rstrTag,
  output slotStrobeT       stb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] getIdx,
  output logic [IDX_W-1:0] saveIdx,
  output logic             getOk,
  output logic             errPut,
  output logic             errGet,
  output logic             saveValid,
  output logic [IDX_W-1:0] saveTag,
  output logic             busy
);

  localparam bit IS_FIFO = (MODE == PAIR_FIFO);

  logic [DEPTH-1:0] validQ, validD;
  logic [IDX_W-1:0] headQ, tailQ;
  logic             saveActQ, saveActD;
  logic [IDX_W-1:0] putIdx, rstrIdx, lowIdx;
  logic             normalOp, getHit, putRoom, putOk, rstrRoom, rstrOk, wrEn;

  // Lowest valid slot, drain order in tagged mode
  always_comb begin
    lowIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (validQ[i]) lowIdx = IDX_W'(i);
    end
  end

  // Slot selection: pointers in FIFO mode, tags in tagged mode
  assign getIdx  = IS_FIFO ? headQ : getTag;
  assign putIdx  = IS_FIFO ? tailQ : putTag;
  assign rstrIdx = IS_FIFO ? tailQ : rstrTag;
  assign saveIdx = IS_FIFO ? headQ : lowIdx;

  assign normalOp = !flush && !saveActQ;
  assign getHit   = normalOp && getValid && validQ[getIdx];
  assign errGet   = normalOp && getValid && !validQ[getIdx];

  // A same-cycle get of the target slot frees it before the write
  assign putRoom  = !validQ[putIdx] || (getHit && (getIdx == putIdx));
  assign rstrRoom = !validQ[rstrIdx] || (getHit && (getIdx == rstrIdx));

  assign putOk  = normalOp && putValid && (IS_FIFO ? putRoom : 1'b1);
  assign errPut = normalOp && putValid && !putRoom;
  assign rstrOk = normalOp && rstrValid && !putValid && (IS_FIFO ? rstrRoom : 1'b1);
  assign wrEn   = putOk || rstrOk;
  assign wrIdx  = putValid ? putIdx : rstrIdx;

  always_comb begin
    validD = validQ;
    if (getHit)   validD[getIdx]  = 1'b0;
    if (saveActQ) validD[saveIdx] = 1'b0;
    if (wrEn)     validD[wrIdx]   = 1'b1;
    if (flush)    validD          = '0;
  end

  always_comb begin
    if (flush)         saveActD = 1'b0;
    else if (saveActQ) saveActD = |validD;
    else               saveActD = saveReq && (|validD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= '0;
      headQ    <= '0;
      tailQ    <= '0;
      saveActQ <= 1'b0;
    end else begin
      validQ   <= validD;
      saveActQ <= saveActD;
      if (flush) begin
        headQ <= '0;
        tailQ <= '0;
      end else begin
        if (getHit || saveActQ) headQ <= headQ + IDX_W'(1);
        if (wrEn)               tailQ <= tailQ + IDX_W'(1);
      end
    end
  end

  assign stb.wrEn          = wrEn;
  assign stb.wrFromRestore = !putValid;
  assign stb.getEn         = getHit;
  assign stb.saveEn        = saveActQ;

  assign getOk     = getHit;
  assign saveValid = saveActQ;
  assign saveTag   = saveActQ ? saveIdx : '0;
  assign busy      = |validQ;

  AST_FIFO_OVERFLOW_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (IS_FIFO && errPut) |-> (&validQ)); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !busy); // R10

  AST_SAVE_DRAINS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (saveActQ && !flush) |=> ($countones(validQ) == $past($countones(validQ)) - 1)); // R11

  AST_SAVE_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    saveValid |-> busy); // R11

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!putValid && !getValid && !flush && !saveActQ && !rstrValid) |=> $stable(validQ)); // R9

endmodule

// File: rtl/slotStore.sv
module slotStore
  import slotStorePkg::*;
#(
  parameter pairModeT MODE        = PAIR_FIFO,
  parameter int       REC_W       = 46,
  parameter int       FP_LATENCY  = 6,
  localparam int      DEPTH       = 1 << $clog2(FP_LATENCY),
  localparam int      IDX_W       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             putValid,
  input  logic [IDX_W-1:0] putTag,
  input  logic [REC_W-1:0] putData,
  input  logic             getValid,
  input  logic [IDX_W-1:0] getTag,
  output logic [REC_W-1:0] getData,
  output logic             getOk,
  output logic             errPut,
  output logic             errGet,
  input  logic             flush,
  input  logic             saveReq,
  output logic             saveValid,
  output logic [IDX_W-1:0] saveTag,
  output logic [REC_W-1:0] saveData,
  input  logic             rstrValid,
  input  logic [IDX_W-1:0] rstrTag,
  input  logic [REC_W-1:0] rstrData,
  output logic             busy
);

  slotStrobeT       stb;
  logic [IDX_W-1:0] wrIdx, getIdx, saveIdx;

  slotStoreCtrl #(.MODE(MODE), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .putValid(putValid), .putTag(putTag),
    .getValid(getValid), .getTag(getTag),
    .flush(flush), .saveReq(saveReq),
    .rstrValid(rstrValid), .rstrTag(rstrTag),
    .stb(stb), .wrIdx(wrIdx), .getIdx(getIdx), .saveIdx(saveIdx),
    .getOk(getOk), .errPut(errPut), .errGet(errGet),
    .saveValid(saveValid), .saveTag(saveTag), .busy(busy)
  );

  slotStoreData #(.REC_W(REC_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrIdx(wrIdx), .getIdx(getIdx), .saveIdx(saveIdx),
    .putData(putData), .rstrData(rstrData),
    .getData(getData), .saveData(saveData)
  );

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    errGet |-> (getData == '0)); // R7

  AST_SAVE_DATA_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !saveValid |-> (saveData == '0)); // R11

endmodule

// File: tb/slotStore_tb.sv
module slotStore_tb;
  import slotStorePkg::*;

  localparam int REC_W = 46;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN;
  logic             putValid, getValid, flush, saveReq, rstrValid;
  logic [IDX_W-1:0] putTag, getTag, rstrTag;
  logic [REC_W-1:0] putData, rstrData;

  logic [REC_W-1:0] fGetData, fSaveData, tGetData, tSaveData;
  logic             fGetOk, fErrPut, fErrGet, fSaveValid, fBusy;
  logic             tGetOk, tErrPut, tErrGet, tSaveValid, tBusy;
  logic [IDX_W-1:0] fSaveTag, tSaveTag;

  slotStore #(.MODE(PAIR_FIFO), .REC_W(REC_W), .FP_LATENCY(6)) u_dut (
    .clk(clk), .rstN(rstN),
    .putValid(putValid), .putTag(putTag), .putData(putData),
    .getValid(getValid), .getTag(getTag), .getData(fGetData),
    .getOk(fGetOk), .errPut(fErrPut), .errGet(fErrGet),
    .flush(flush), .saveReq(saveReq),
    .saveValid(fSaveValid), .saveTag(fSaveTag), .saveData(fSaveData),
    .rstrValid(rstrValid), .rstrTag(rstrTag), .rstrData(rstrData),
    .busy(fBusy)
  );

  slotStore #(.MODE(PAIR_TAGGED), .REC_W(REC_W), .FP_LATENCY(6)) u_dutTag (
    .clk(clk), .rstN(rstN),
    .putValid(putValid), .putTag(putTag), .putData(putData),
    .getValid(getValid), .getTag(getTag), .getData(tGetData),
    .getOk(tGetOk), .errPut(tErrPut), .errGet(tErrGet),
    .flush(flush), .saveReq(saveReq),
    .saveValid(tSaveValid), .saveTag(tSaveTag), .saveData(tSaveData),
    .rstrValid(rstrValid), .rstrTag(rstrTag), .rstrData(rstrData),
    .busy(tBusy)
  );

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";

  // Behavioural reference: FIFO as a queue, tagged as a slot array
  logic [REC_W-1:0] fq[$];
  int               fHead = 0;
  bit               fSave = 0;
  logic [REC_W-1:0] tData[DEPTH];
  bit               tVal[DEPTH];
  bit               tSave = 0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  function automatic int tLow();
    for (int i = 0; i < DEPTH; i++) if (tVal[i]) return i;
    return -1;
  endfunction

  function automatic logic [REC_W-1:0] rec(int n);
    return {1'b1, 13'(n * 37), 32'(n * 32'h9E37_79B9)};
  endfunction

  // Inputs are set at the falling edge; compare just before the rising edge, then advance the model
  task automatic cyc();
    bit fNorm, fG, fP, fR, tNorm, tG, tEP, anyT;
    int sz, low;
    #3;
    sz    = fq.size();
    fNorm = !flush && !fSave;
    fG    = fNorm && getValid && sz > 0;
    fP    = fNorm && putValid && (sz < DEPTH || fG);
    fR    = fNorm && rstrValid && !putValid && (sz < DEPTH || fG);
    chk("fifo getOk",  fGetOk, fG);
    chk("fifo getData", fGetData, fG ? fq[0] : '0);
    chk("fifo errGet", fErrGet, fNorm && getValid && sz == 0);
    chk("fifo errPut", fErrPut, fNorm && putValid && !fP);
    chk("fifo saveValid", fSaveValid, fSave);
    chk("fifo saveTag", fSaveTag, fSave ? IDX_W'(fHead) : '0);
    chk("fifo saveData", fSaveData, fSave ? fq[0] : '0);
    chk("fifo busy", fBusy, sz > 0);

    low   = tLow();
    tNorm = !flush && !tSave;
    tG    = tNorm && getValid && tVal[getTag];
    tEP   = tNorm && putValid && tVal[putTag] && !(tG && getTag == putTag);
    chk("tag getOk", tGetOk, tG);
    chk("tag getData", tGetData, tG ? tData[getTag] : '0);
    chk("tag errGet", tErrGet, tNorm && getValid && !tVal[getTag]);
    chk("tag errPut", tErrPut, tEP);
    chk("tag saveValid", tSaveValid, tSave);
    chk("tag saveTag", tSaveTag, tSave ? IDX_W'(low) : '0);
    chk("tag saveData", tSaveData, tSave ? tData[low] : '0);
    chk("tag busy", tBusy, low >= 0);

    @(posedge clk);
    if (flush) begin
      fq.delete(); fHead = 0; fSave = 0;
    end else if (fSave) begin
      void'(fq.pop_front()); fHead = (fHead + 1) % DEPTH; fSave = fq.size() > 0;
    end else begin
      if (fG) begin void'(fq.pop_front()); fHead = (fHead + 1) % DEPTH; end
      if (fP) fq.push_back(putData);
      else if (fR) fq.push_back(rstrData);
      fSave = saveReq && fq.size() > 0;
    end

    if (flush) begin
      for (int i = 0; i < DEPTH; i++) tVal[i] = 0;
      tSave = 0;
    end else if (tSave) begin
      tVal[low] = 0;
      tSave = tLow() >= 0;
    end else begin
      if (tG) tVal[getTag] = 0;
      if (putValid) begin tVal[putTag] = 1; tData[putTag] = putData; end
      else if (rstrValid) begin tVal[rstrTag] = 1; tData[rstrTag] = rstrData; end
      tSave = saveReq && tLow() >= 0;
    end
    @(negedge clk);
  endtask

  task automatic idleIn();
    putValid = 0; getValid = 0; flush = 0; saveReq = 0; rstrValid = 0;
    putTag = '0; getTag = '0; rstrTag = '0; putData = '0; rstrData = '0;
  endtask

  task automatic op(bit pv, int pt, logic [REC_W-1:0] pd, bit gv, int gt,
                    bit fl = 0, bit sr = 0, bit rv = 0, int rt = 0,
                    logic [REC_W-1:0] rd = '0);
    putValid = pv; putTag = IDX_W'(pt); putData = pd;
    getValid = gv; getTag = IDX_W'(gt);
    flush = fl; saveReq = sr;
    rstrValid = rv; rstrTag = IDX_W'(rt); rstrData = rd;
    cyc();
    idleIn();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin tVal[i] = 0; tData[i] = '0; end
    idleIn();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    curReq = "R1";  // reset state
    op(0, 0, '0, 0, 0);
    op(0, 0, '0, 0, 0);

    curReq = "R2";  // order, and put+get on a non-empty store
    for (int i = 0; i < 3; i++) op(1, i, rec(i), 0, 0);
    op(1, 3, rec(3), 1, 0);
    for (int i = 1; i < 4; i++) op(0, 0, '0, 1, i);

    curReq = "R8";  // exactly 8 slots, bit 45 kept
    for (int i = 0; i < DEPTH; i++) op(1, i, rec(10 + i), 0, 0);
    curReq = "R3";  // overflow, and full put+get
    op(1, 4, rec(30), 0, 0);
    op(1, 0, rec(31), 1, 0);
    curReq = "R9";
    for (int i = 0; i < DEPTH; i++) op(0, 0, '0, 1, (i + 1) % DEPTH);
    op(0, 0, '0, 0, 0);

    curReq = "R4";  // underflow, put+get on empty
    op(0, 0, '0, 1, 2);
    op(1, 2, rec(40), 1, 2);
    op(0, 0, '0, 1, 2);

    curReq = "R5";  // out-of-order tagged pairs
    op(1, 5, rec(50), 0, 0);
    op(1, 2, rec(51), 0, 0);
    op(1, 7, rec(52), 0, 0);
    op(0, 0, '0, 1, 7);
    op(0, 0, '0, 1, 5);
    op(0, 0, '0, 1, 2);

    curReq = "R6";  // overwrite and same-cycle replace
    op(1, 3, rec(60), 0, 0);
    op(1, 3, rec(61), 0, 0);
    op(1, 3, rec(62), 1, 3);
    op(0, 0, '0, 1, 3);
    op(0, 0, '0, 1, 3);

    curReq = "R7";  // empty slot read
    op(0, 0, '0, 1, 6);
    op(0, 0, '0, 1, 0);

    curReq = "R10"; // flush beats everything
    op(1, 1, rec(70), 0, 0);
    op(1, 4, rec(71), 0, 0);
    op(1, 6, rec(72), 1, 1, 1, 1, 0, 0, '0);
    op(0, 0, '0, 1, 4);
    op(1, 0, rec(73), 0, 0);
    op(0, 0, '0, 1, 0);

    curReq = "R11"; // save drain with competing requests
    op(1, 6, rec(80), 0, 0);
    op(1, 1, rec(81), 0, 0);
    op(1, 4, rec(82), 0, 0);
    op(0, 0, '0, 0, 0, 0, 1);
    op(1, 2, rec(83), 1, 1, 0, 1, 1, 5, rec(84));
    op(0, 0, '0, 1, 4, 0, 0, 1, 3, rec(85));
    op(0, 0, '0, 0, 0);
    op(0, 0, '0, 0, 0);
    op(1, 5, rec(86), 0, 0);
    op(0, 0, '0, 0, 0, 0, 1);
    op(1, 0, rec(87), 0, 0, 1);
    op(0, 0, '0, 0, 0);

    curReq = "R12"; // restore paths
    op(0, 0, '0, 0, 0, 0, 0, 1, 6, rec(90));
    op(0, 0, '0, 0, 0, 0, 0, 1, 2, rec(91));
    op(1, 2, rec(92), 0, 0, 0, 0, 1, 5, rec(93));
    op(0, 0, '0, 1, 6);
    op(0, 0, '0, 1, 2);
    op(0, 0, '0, 1, 5);
    for (int i = 0; i < DEPTH; i++) op(0, 0, '0, 0, 0, 0, 0, 1, i, rec(100 + i));
    op(0, 0, '0, 0, 0, 0, 0, 1, 3, rec(120));
    op(0, 0, '0, 1, 3, 0, 0, 1, 3, rec(121));
    for (int i = 0; i < DEPTH; i++) op(0, 0, '0, 1, i);
    op(0, 0, '0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule